// File: doc/BRIEF.md
# PHY-side link interface controller

This block sits at the physical-layer end of a parallel interface between a PHY and a link-layer controller. It owns a 2-bit control bus and a data bus of `DATA_W` lanes, both updated and sampled on the rising edge of one interface clock. While it holds the buses, it reports idle, status transfers, received packets and transmit grants to the link layer. It packs received bytes and status bits onto the data lanes according to the selected transfer speed, and forces unused lanes to zero.

The core of the PHY presents three kinds of work. `rx_valid` with `rx_data` is a packet coming in from the serial bus. `st_valid` with `st_data` is a status transfer, started either by the PHY itself or in answer to a register read. `grant_req` pulses once the PHY has won the serial bus. A grant drives the grant code for one cycle and then turns off the PHY's drivers, which hands both buses to the link. From then on the block samples the link's control code. It forwards transmitted data on `tx_valid`/`tx_data` and takes the buses back when the link returns to idle.

The bidirectional pins are split into separate drive values, sample values and a single output enable, so the pad ring can build the tristate buffers.

Top module: `phy_link_port`

## Requirements
- R1: During and after reset, and whenever the PHY drives the idle code 00, `ctl_o` is 00, `bus_oe` is 1, `d_o` is all zero and `tx_valid` is 0.
- R2: If `rx_valid` is sampled high while idle or receiving, then on the next cycle `ctl_o` is 10 and `d_o` holds that cycle's `rx_data`, masked by speed. Receiving goes on for as long as `rx_valid` stays high.
- R3: The speed code picks which lanes carry data. For 00, only lanes 0–1 carry data. For 01, lanes 0–3 carry data. For 10 and 11, all lanes carry data. Lanes outside that set are driven 0. The speed code is sampled on the same edge as the data.
- R4: A status transfer drives `ctl_o` = 01. Only lanes 0–1 of `st_data` reach `d_o`; every other lane is 0, whatever the speed.
- R5: When a status or receive code ends, `ctl_o` shows 00 for at least one cycle before any other non-idle code.
- R6: When several requests are present in an idle cycle, the order of service is receive first, then grant, then status.
- R7: A grant drives `ctl_o` = 11 with `bus_oe` = 1 for exactly one cycle. `bus_oe` then goes to 0. `bus_oe` never falls at any other time.
- R8: While released, `ctl_o` and `d_o` are 0. Link code 01 (hold) or 10 (transmit) keeps the buses released. Link code 00 (idle) or 11 (reserved) makes the next cycle show `bus_oe` = 1 and `ctl_o` = 00. `ctl_i` has no effect while the PHY owns the bus.
- R9: While released, link code 10 makes the next cycle show `tx_valid` = 1 with `tx_data` = `d_i` masked by speed. In every other cycle `tx_valid` is 0 and `tx_data` is 0.
- R10: A `grant_req` pulse that arrives while the block is busy is kept. It is served in the first idle cycle that has no receive request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| speed | input | 2 | Transfer speed: 00 low, 01 middle, 10/11 high |
| rx_valid | input | 1 | Received packet data present this cycle |
| rx_data | input | DATA_W | Received packet data |
| st_valid | input | 1 | Status transfer data present this cycle |
| st_data | input | DATA_W | Status bits (lanes 0–1 used) |
| grant_req | input | 1 | Pulse: serial bus won, grant the link |
| ctl_i | input | 2 | Control bus as sampled from the pins |
| d_i | input | DATA_W | Data bus as sampled from the pins |
| ctl_o | output | 2 | Control bus drive value |
| d_o | output | DATA_W | Data bus drive value |
| bus_oe | output | 1 | Output enable for control and data pins |
| tx_valid | output | 1 | Link transmit data captured |
| tx_data | output | DATA_W | Captured link transmit data, lane-masked |

## Verification
The assertions assume only two things about the link. First, its code on `ctl_i` matters only while `bus_oe` is low. Second, `speed` may change on any cycle, which is why the lane checks compare against the speed from the previous cycle. To test that `ctl_i` and `d_i` are ignored while the PHY owns the bus, the stimulus drives random codes and data on them in every cycle, including cycles the PHY owns. The reserved code 11 appears both while owned and while released. Request inputs are random, with weights that give long receive runs, grants that overlap busy periods, and link hold and transmit stretches.

// File: rtl/phy_link_pkg.sv
package phy_link_pkg;

    // Code driven by the PHY on the control bus
    typedef enum logic [1:0] {
        PCTL_IDLE    = 2'b00,
        PCTL_STATUS  = 2'b01,
        PCTL_RECEIVE = 2'b10,
        PCTL_GRANT   = 2'b11
    } phy_ctl_e;

    // Code driven by the link while it holds the control bus
    typedef enum logic [1:0] {
        LCTL_IDLE = 2'b00,
        LCTL_HOLD = 2'b01,
        LCTL_XMIT = 2'b10,
        LCTL_RSVD = 2'b11
    } link_ctl_e;

    typedef enum logic [1:0] {
        SPD_LOW  = 2'b00,
        SPD_MID  = 2'b01,
        SPD_HIGH = 2'b10,
        SPD_ALT  = 2'b11
    } speed_e;

    typedef enum logic [2:0] {
        OWN_IDLE,
        OWN_STATUS,
        OWN_RECV,
        OWN_GRANT,
        OWN_LINK
    } own_state_e;

    typedef enum logic [1:0] {
        DSEL_ZERO,
        DSEL_RX,
        DSEL_STATUS
    } dsel_e;

    typedef struct packed {
        phy_ctl_e ctl;
        logic     oe;
        dsel_e    dsel;
    } drive_t;

    localparam int STATUS_LANES = 2;

    // Pin drive set up for a given ownership state
    function automatic drive_t drive_for(own_state_e s);
        drive_t d;
        d.ctl  = PCTL_IDLE;
        d.oe   = 1'b1;
        d.dsel = DSEL_ZERO;
        case (s)
            OWN_STATUS: begin d.ctl = PCTL_STATUS;  d.dsel = DSEL_STATUS; end
            OWN_RECV:   begin d.ctl = PCTL_RECEIVE; d.dsel = DSEL_RX;     end
            OWN_GRANT:  d.ctl = PCTL_GRANT;
            OWN_LINK:   d.oe  = 1'b0;
            default:    d.ctl = PCTL_IDLE;
        endcase
        return d;
    endfunction

    function automatic logic link_gives_back(link_ctl_e c);
        return (c == LCTL_IDLE) || (c == LCTL_RSVD);
    endfunction

endpackage

// File: rtl/plink_lane_mask.sv
module plink_lane_mask
    import phy_link_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int FIXED_LANES = 0
) (
    input  logic [1:0]        speed,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int LANES_LOW = DATA_W / 4;
    localparam int LANES_MID = DATA_W / 2;

    logic [DATA_W-1:0] keep;

    generate
        if (FIXED_LANES > 0) begin : g_fixed
            logic unused_speed;
            assign unused_speed = ^speed;
            for (genvar i = 0; i < DATA_W; i++) begin : g_lane
                assign keep[i] = (i < FIXED_LANES);
            end
        end else begin : g_speed
            for (genvar i = 0; i < DATA_W; i++) begin : g_lane
                assign keep[i] = (speed == SPD_LOW) ? (i < LANES_LOW) :
                                 (speed == SPD_MID) ? (i < LANES_MID) : 1'b1;
            end
        end
    endgenerate

    assign dout = din & keep;
endmodule

// File: rtl/plink_grant_hold.sv
module plink_grant_hold (
    input  logic clk,
    input  logic rst,
    input  logic grant_req,
    input  logic grant_take,
    output logic grant_want
);
    logic pend_q;

    assign grant_want = pend_q | grant_req;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= grant_want & ~grant_take;
    end
endmodule

// File: rtl/plink_owner_fsm.sv
module plink_owner_fsm
    import phy_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic       st_valid,
    input  logic       grant_want,
    input  logic [1:0] link_ctl,
    output own_state_e state_q,
    output logic       grant_take,
    output dsel_e      dsel_nxt,
    output logic [1:0] ctl_q,
    output logic       oe_q
);
    own_state_e nxt;
    drive_t     drv_nxt;

    always_comb begin
        nxt        = state_q;
        grant_take = 1'b0;
        case (state_q)
            OWN_IDLE: begin
                if (rx_valid) begin
                    nxt = OWN_RECV;
                end else if (grant_want) begin
                    nxt        = OWN_GRANT;
                    grant_take = 1'b1;
                end else if (st_valid) begin
                    nxt = OWN_STATUS;
                end
            end
            OWN_STATUS: nxt = st_valid ? OWN_STATUS : OWN_IDLE;
            OWN_RECV:   nxt = rx_valid ? OWN_RECV : OWN_IDLE;
            OWN_GRANT:  nxt = OWN_LINK;
            OWN_LINK:   nxt = link_gives_back(link_ctl_e'(link_ctl)) ? OWN_IDLE : OWN_LINK;
            default:    nxt = OWN_IDLE;
        endcase
        drv_nxt  = drive_for(nxt);
        dsel_nxt = drv_nxt.dsel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OWN_IDLE;
            ctl_q   <= PCTL_IDLE;
            oe_q    <= 1'b1;
        end else begin
            state_q <= nxt;
            ctl_q   <= drv_nxt.ctl;
            oe_q    <= drv_nxt.oe;
        end
    end
endmodule

// File: rtl/plink_tx_capture.sv
module plink_tx_capture
    import phy_link_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              released,
    input  logic [1:0]        link_ctl,
    input  logic [DATA_W-1:0] masked_d,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data
);
    logic take;
    assign take = released && (link_ctl_e'(link_ctl) == LCTL_XMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= take;
            tx_data  <= take ? masked_d : '0;
        end
    end
endmodule

// File: rtl/phy_link_port.sv
module phy_link_port
    import phy_link_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        speed,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              st_valid,
    input  logic [DATA_W-1:0] st_data,
    input  logic              grant_req,
    input  logic [1:0]        ctl_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [1:0]        ctl_o,
    output logic [DATA_W-1:0] d_o,
    output logic              bus_oe,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data
);
    own_state_e        state_q;
    logic              grant_want;
    logic              grant_take;
    dsel_e             dsel_nxt;
    logic [DATA_W-1:0] rx_m;
    logic [DATA_W-1:0] st_m;
    logic [DATA_W-1:0] tx_m;
    logic [DATA_W-1:0] d_q;

    plink_grant_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .grant_req  (grant_req),
        .grant_take (grant_take),
        .grant_want (grant_want)
    );

    plink_owner_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .st_valid   (st_valid),
        .grant_want (grant_want),
        .link_ctl   (ctl_i),
        .state_q    (state_q),
        .grant_take (grant_take),
        .dsel_nxt   (dsel_nxt),
        .ctl_q      (ctl_o),
        .oe_q       (bus_oe)
    );

    plink_lane_mask #(.DATA_W(DATA_W), .FIXED_LANES(0)) u_rx_mask (
        .speed (speed), .din (rx_data), .dout (rx_m)
    );

    plink_lane_mask #(.DATA_W(DATA_W), .FIXED_LANES(STATUS_LANES)) u_st_mask (
        .speed (speed), .din (st_data), .dout (st_m)
    );

    plink_lane_mask #(.DATA_W(DATA_W), .FIXED_LANES(0)) u_tx_mask (
        .speed (speed), .din (d_i), .dout (tx_m)
    );

    plink_tx_capture #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .released (state_q == OWN_LINK),
        .link_ctl (ctl_i),
        .masked_d (tx_m),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
        end else begin
            case (dsel_nxt)
                DSEL_RX:     d_q <= rx_m;
                DSEL_STATUS: d_q <= st_m;
                default:     d_q <= '0;
            endcase
        end
    end

    assign d_o = d_q;
endmodule

// File: rtl/plink_checker.sv
module plink_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        speed,
    input logic [1:0]        ctl_i,
    input logic [1:0]        ctl_o,
    input logic [DATA_W-1:0] d_o,
    input logic              bus_oe,
    input logic              tx_valid
);
    localparam int LANES_LOW = DATA_W / 4;

    assert_idle_data_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && ctl_o == 2'b00) |-> (d_o == '0));

    assert_low_speed_lanes_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && ctl_o == 2'b10 && $past(speed) == 2'b00) |-> ((d_o >> LANES_LOW) == '0));

    assert_status_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && ctl_o == 2'b01) |-> ((d_o >> 2) == '0));

    assert_idle_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && (ctl_o == 2'b01 || ctl_o == 2'b10)) |=> (ctl_o == $past(ctl_o) || ctl_o == 2'b00));

    assert_grant_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && ctl_o == 2'b11) |=> !bus_oe);

    assert_release_only_after_grant_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_oe) |-> ($past(ctl_o) == 2'b11));

    assert_reclaim_R8: assert property (@(posedge clk) disable iff (rst)
        (!bus_oe && (ctl_i == 2'b00 || ctl_i == 2'b11)) |=> (bus_oe && ctl_o == 2'b00));

    assert_tx_only_released_R9: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(!bus_oe && ctl_i == 2'b10));
endmodule

bind phy_link_port plink_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .speed    (speed),
    .ctl_i    (ctl_i),
    .ctl_o    (ctl_o),
    .d_o      (d_o),
    .bus_oe   (bus_oe),
    .tx_valid (tx_valid)
);

// File: tb/tb_phy_link_port.sv
`timescale 1ns/1ps
module tb_phy_link_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] speed = 2'b00;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       st_valid = 1'b0;
    logic [7:0] st_data = 8'h00;
    logic       grant_req = 1'b0;
    logic [1:0] ctl_i = 2'b00;
    logic [7:0] d_i = 8'h00;
    logic [1:0] ctl_o;
    logic [7:0] d_o;
    logic       bus_oe;
    logic       tx_valid;
    logic [7:0] tx_data;

    always #2.5 clk = ~clk;

    phy_link_port #(.DATA_W(8)) dut (
        .clk(clk), .rst(rst), .speed(speed),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .st_valid(st_valid), .st_data(st_data),
        .grant_req(grant_req), .ctl_i(ctl_i), .d_i(d_i),
        .ctl_o(ctl_o), .d_o(d_o), .bus_oe(bus_oe),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // reference model state: 0 idle, 1 status, 2 receive, 3 grant, 4 released
    int         m_st   = 0;
    bit         m_pend = 0;
    logic [1:0] e_ctl  = 2'b00;
    logic       e_oe   = 1'b1;
    logic [7:0] e_d    = 8'h00;
    logic       e_txv  = 1'b0;
    logic [7:0] e_txd  = 8'h00;
    string      e_tag  = "R1";
    logic [1:0] prev_ctl = 2'b00;
    logic       prev_oe  = 1'b1;

    function automatic logic [7:0] lane_mask(logic [7:0] d, logic [1:0] spd);
        if (spd == 2'b00) return d & 8'h03;
        if (spd == 2'b01) return d & 8'h0F;
        return d;
    endfunction

    task automatic model_step(bit rxv, logic [7:0] rxd, bit stv, logic [7:0] std,
                              bit greq, logic [1:0] spd, logic [1:0] ctli, logic [7:0] di);
        int n;
        bit want, take;
        e_txv = (m_st == 4) && (ctli == 2'b10);
        e_txd = e_txv ? lane_mask(di, spd) : 8'h00;
        want  = m_pend | greq;
        take  = 0;
        n     = m_st;
        case (m_st)
            0: begin
                if (rxv) n = 2;
                else if (want) begin n = 3; take = 1; end
                else if (stv) n = 1;
                else n = 0;
            end
            1: n = stv ? 1 : 0;
            2: n = rxv ? 2 : 0;
            3: n = 4;
            default: n = (ctli == 2'b00 || ctli == 2'b11) ? 0 : 4;
        endcase
        m_pend = want & !take;
        e_oe = 1'b1; e_d = 8'h00; e_ctl = 2'b00;
        case (n)
            1: begin e_ctl = 2'b01; e_d = std & 8'h03; e_tag = "R4"; end
            2: begin e_ctl = 2'b10; e_d = lane_mask(rxd, spd); e_tag = "R2 R3"; end
            3: begin e_ctl = 2'b11; e_tag = "R7"; end
            4: begin e_oe = 1'b0; e_tag = "R8 R9"; end
            default: e_tag = "R1";
        endcase
        m_st = n;
    endtask

    task automatic check_outputs(string tag);
        n_checks++;
        if (ctl_o !== e_ctl || bus_oe !== e_oe || d_o !== e_d ||
            tx_valid !== e_txv || tx_data !== e_txd) begin
            n_fail++;
            $display("FAIL %s: ctl=%b oe=%b d=%h txv=%b txd=%h expected ctl=%b oe=%b d=%h txv=%b txd=%h",
                     tag, ctl_o, bus_oe, d_o, tx_valid, tx_data, e_ctl, e_oe, e_d, e_txv, e_txd);
        end
        // R5: a status or receive code is never followed directly by another non-idle code
        if (prev_oe && (prev_ctl == 2'b01 || prev_ctl == 2'b10) && ctl_o != prev_ctl) begin
            n_checks++;
            if (!(bus_oe && ctl_o == 2'b00)) begin
                n_fail++;
                $display("FAIL R5: ctl=%b oe=%b after %b expected ctl=00 oe=1", ctl_o, bus_oe, prev_ctl);
            end
        end
        prev_ctl = ctl_o;
        prev_oe  = bus_oe;
    endtask

    task automatic step(bit rxv, logic [7:0] rxd, bit stv, logic [7:0] std, bit greq,
                        logic [1:0] spd, logic [1:0] ctli, logic [7:0] di, string tag);
        rx_valid = rxv; rx_data = rxd; st_valid = stv; st_data = std;
        grant_req = greq; speed = spd; ctl_i = ctli; d_i = di;
        model_step(rxv, rxd, stv, std, greq, spd, ctli, di);
        @(negedge clk);
        check_outputs(tag == "" ? e_tag : tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1394));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check_outputs("R1");   // R1 reset state

        // R6: all three requests in one idle cycle, receive wins
        step(1, 8'hA5, 1, 8'hFF, 1, 2'b10, 2'b10, 8'h5A, "R6");
        step(0, 8'h00, 1, 8'hFF, 0, 2'b10, 2'b00, 8'h00, "R5");
        // R10: kept grant served before waiting status
        step(0, 8'h00, 1, 8'hFF, 0, 2'b10, 2'b00, 8'h00, "R10 R6");
        step(0, 8'h00, 1, 8'hFF, 0, 2'b10, 2'b01, 8'h00, "R7");
        step(0, 8'h00, 1, 8'hFF, 0, 2'b10, 2'b01, 8'hFF, "R8");
        step(0, 8'h00, 1, 8'hFF, 0, 2'b00, 2'b10, 8'hFF, "R9");
        step(0, 8'h00, 1, 8'hFF, 0, 2'b01, 2'b10, 8'hFF, "R9");
        step(0, 8'h00, 1, 8'hFF, 0, 2'b10, 2'b11, 8'hFF, "R8");
        // R4: status at high speed still only lanes 0-1
        step(0, 8'h00, 1, 8'hFF, 0, 2'b10, 2'b00, 8'h00, "R4");
        step(0, 8'h00, 0, 8'h00, 0, 2'b10, 2'b00, 8'h00, "R5");
        // R3: each speed code
        for (int s = 0; s < 4; s++) begin
            step(1, 8'hFF, 0, 8'h00, 0, 2'(s), 2'b00, 8'h00, "R3");
        end
        step(0, 8'h00, 0, 8'h00, 0, 2'b00, 2'b00, 8'h00, "R5");
        // R8: link code ignored while PHY owns the bus
        step(0, 8'h00, 0, 8'h00, 0, 2'b10, 2'b10, 8'hC3, "R8");
        step(0, 8'h00, 0, 8'h00, 0, 2'b10, 2'b11, 8'h3C, "R8");

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            bit rxv, stv, greq;
            logic [1:0] ctli;
            rxv  = (m_st == 2) ? ($urandom % 5 != 0) : ($urandom % 4 == 0);
            stv  = (m_st == 1) ? ($urandom % 3 != 0) : ($urandom % 4 == 0);
            greq = ($urandom % 8 == 0);
            case ($urandom % 8)
                0: ctli = 2'b00;
                1: ctli = 2'b11;
                2, 3, 4: ctli = 2'b10;
                default: ctli = 2'b01;
            endcase
            step(rxv, 8'($urandom), stv, 8'($urandom), greq, 2'($urandom), ctli, 8'($urandom), "");
        end
        finish_run();
    end
endmodule